// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the execute stage of a small accumulator machine that uses one-byte opcodes. A sequencer upstream fetches the operands and presents them on the inputs together with the opcode. The operands are the accumulator, a second operand (a bank register or a byte read through a pointer register), the B register, and the incoming carry, half-carry and overflow flags. The block works out the new accumulator, the new B value and the new flags. One cycle after it accepts a request it presents them on registered outputs.

The supported operations are add, add with carry, bitwise AND, clear and complement of the accumulator, clear and invert of the carry, increment, decrement, decimal adjust and unsigned divide. For the register and pointer forms, the low opcode bits only choose where the operand came from. Both forms arrive on the same operand port, so they behave the same here. Requests use a valid/ready handshake. A result that has not been taken holds its value and stops new requests from being accepted.

Top module: `acc_alu`

## Requirements
- R1: Opcodes 0x28–0x2F and 0x26–0x27 write A+operand (mod 256) to the accumulator. CY is set to the carry out of bit 7. AC is set to the carry out of bit 3. OV is set when both operands have the same bit 7 and the result's bit 7 differs. Each flag is written both ways (set or cleared).
- R2: Opcodes 0x38–0x3F and 0x36–0x37 behave as R1, with the incoming CY added into the sum, the nibble carry and the overflow.
- R3: Opcodes 0x58–0x5F and 0x56–0x57 write A AND operand to the accumulator and leave CY, AC and OV unchanged.
- R4: 0xE4 gives accumulator 0x00 and 0xF4 gives the bitwise complement of A. Both leave the flags unchanged.
- R5: 0xC3 gives CY=0 and 0xB3 gives CY inverted. The accumulator, B, AC and OV pass through.
- R6: 0x04 gives A+1 and 0x14 gives A−1, both modulo 256, with the flags unchanged.
- R7: 0xD4 first adds 0x06 when the low nibble exceeds 9 or AC is 1. It then adds 0x60 when the resulting high nibble exceeds 9, or CY is 1, or the first step carried out of bit 7. CY becomes 1 if either step carries out of bit 7, and a CY of 1 is never cleared. AC and OV are unchanged.
- R8: 0x84 with a nonzero B gives accumulator = A/B and B = A mod B (unsigned), with CY=0, OV=0 and AC unchanged.
- R9: 0x84 with B=0 leaves the accumulator and B unchanged, with OV=1, CY=0 and AC unchanged.
- R10: Any other opcode passes the accumulator, B and all three flags through unchanged.
- R11: A request is accepted on a clock edge where in_valid and in_ready are both 1. Its result appears with out_valid=1 after that edge.
- R12: While out_valid=1 and out_ready=0, in_ready is 0 and all outputs hold their values.
- R13: After reset, out_valid is 0 and every data and flag output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request |
| opcode | input | 8 | Instruction byte |
| acc_in | input | W | Current accumulator |
| opnd_in | input | W | Second operand (register or pointed-to byte) |
| b_in | input | W | Current B register |
| cy_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current half-carry flag |
| ov_in | input | 1 | Current overflow flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| acc_out | output | W | New accumulator |
| b_out | output | W | New B register |
| cy_out | output | 1 | New carry flag |
| ac_out | output | 1 | New half-carry flag |
| ov_out | output | 1 | New overflow flag |

## Verification
The bench builds the block with its default width of 8. This is the only width for which the opcode values, the nibble boundaries of the decimal adjust and the 0x06/0x60 corrections have their intended meaning. At this width the directed operands can reach every corner of interest:
- the 0xFF/0x00 wrap of increment and decrement,
- signed overflow in both directions,
- a half-carry produced only by the carry-in,
- a decimal adjust whose first correction carries out of bit 7,
- a divide by zero and a divide by a divisor larger than the dividend.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    K_NOP, K_ADD, K_ADDC, K_AND, K_CLRA, K_CPLA,
    K_CLRC, K_CPLC, K_DA, K_INC, K_DEC, K_DIV
  } op_kind_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } flags_t;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  logic [7:0] opcode,
  output op_kind_e   kind
);
  always_comb begin
    casez (opcode)
      8'b0010_1???, 8'b0010_011?: kind = K_ADD;
      8'b0011_1???, 8'b0011_011?: kind = K_ADDC;
      8'b0101_1???, 8'b0101_011?: kind = K_AND;
      8'hE4:                      kind = K_CLRA;
      8'hF4:                      kind = K_CPLA;
      8'hC3:                      kind = K_CLRC;
      8'hB3:                      kind = K_CPLC;
      8'hD4:                      kind = K_DA;
      8'h04:                      kind = K_INC;
      8'h14:                      kind = K_DEC;
      8'h84:                      kind = K_DIV;
      default:                    kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cy,
  output logic         ac,
  output logic         ov
);
  localparam int NIB = W / 2;

  logic [W:0]   full;
  logic [NIB:0] low;

  always_comb begin
    full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    low  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
    sum  = full[W-1:0];
    cy   = full[W];
    ac   = low[NIB];
    ov   = (a[W-1] == b[W-1]) && (full[W-1] != a[W-1]);
  end
endmodule

// File: rtl/acc_alu_bcd.sv
module acc_alu_bcd #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         ac,
  input  logic         cy,
  output logic [W-1:0] res,
  output logic         cy_out
);
  localparam int     NIB   = W / 2;
  localparam [W:0]   LOFIX = (W+1)'(6);
  localparam [W:0]   HIFIX = (W+1)'(6) << NIB;
  localparam [NIB:0] NINE  = (NIB+1)'(9);

  logic [W:0] step1;
  logic [W:0] step2;
  logic       lo_adj;
  logic       hi_adj;

  always_comb begin
    lo_adj = ({1'b0, a[NIB-1:0]} > NINE) || ac;
    step1  = {1'b0, a} + (lo_adj ? LOFIX : '0);
    hi_adj = ({1'b0, step1[W-1:NIB]} > NINE) || cy || step1[W];
    step2  = {1'b0, step1[W-1:0]} + (hi_adj ? HIFIX : '0);
    res    = step2[W-1:0];
    cy_out = cy | step1[W] | step2[W];
  end
endmodule

// File: rtl/acc_alu_divider.sv
module acc_alu_divider #(
  parameter int W = 8
) (
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  logic [W-1:0] rem_s [0:W];
  logic [W-1:0] quo;

  assign rem_s[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_stage
    logic [W:0] trial;
    logic       take;
    assign trial = {rem_s[i], dividend[W-1-i]};
    assign take  = (trial >= {1'b0, divisor});
    assign quo[W-1-i] = take;
    assign rem_s[i+1] = take ? W'(trial - {1'b0, divisor}) : trial[W-1:0];
  end

  assign quotient  = quo;
  assign remainder = rem_s[W];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [7:0]   opcode,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opnd_in,
  input  logic [W-1:0] b_in,
  input  logic         cy_in,
  input  logic         ac_in,
  input  logic         ov_in,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] acc_out,
  output logic [W-1:0] b_out,
  output logic         cy_out,
  output logic         ac_out,
  output logic         ov_out
);
  op_kind_e     kind;
  logic [W-1:0] add_sum, bcd_res, div_q, div_r;
  logic         add_cy, add_ac, add_ov, bcd_cy, add_cin;
  logic [W-1:0] nx_acc, nx_b;
  flags_t       nx_f, f_q;
  logic [W-1:0] acc_q, b_q;
  logic         vld_q;
  logic         fire;

  acc_alu_decode u_dec (.opcode(opcode), .kind(kind));

  assign add_cin = (kind == K_ADDC) & cy_in;

  acc_alu_adder #(.W(W)) u_add (
    .a(acc_in), .b(opnd_in), .cin(add_cin),
    .sum(add_sum), .cy(add_cy), .ac(add_ac), .ov(add_ov)
  );

  acc_alu_bcd #(.W(W)) u_bcd (
    .a(acc_in), .ac(ac_in), .cy(cy_in), .res(bcd_res), .cy_out(bcd_cy)
  );

  acc_alu_divider #(.W(W)) u_div (
    .dividend(acc_in), .divisor(b_in), .quotient(div_q), .remainder(div_r)
  );

  always_comb begin
    nx_acc = acc_in;
    nx_b   = b_in;
    nx_f   = '{cy: cy_in, ac: ac_in, ov: ov_in};
    case (kind)
      K_ADD, K_ADDC: begin
        nx_acc = add_sum;
        nx_f   = '{cy: add_cy, ac: add_ac, ov: add_ov};
      end
      K_AND:  nx_acc = acc_in & opnd_in;
      K_CLRA: nx_acc = '0;
      K_CPLA: nx_acc = ~acc_in;
      K_CLRC: nx_f.cy = 1'b0;
      K_CPLC: nx_f.cy = ~cy_in;
      K_INC:  nx_acc = acc_in + W'(1);
      K_DEC:  nx_acc = acc_in - W'(1);
      K_DA: begin
        nx_acc  = bcd_res;
        nx_f.cy = bcd_cy;
      end
      K_DIV: begin
        nx_f.cy = 1'b0;
        if (b_in == '0) begin
          nx_f.ov = 1'b1;
        end else begin
          nx_acc  = div_q;
          nx_b    = div_r;
          nx_f.ov = 1'b0;
        end
      end
      default: ;
    endcase
  end

  assign in_ready = ~vld_q | out_ready;
  assign fire     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      acc_q <= '0;
      b_q   <= '0;
      f_q   <= '0;
    end else begin
      if (fire) begin
        vld_q <= 1'b1;
        acc_q <= nx_acc;
        b_q   <= nx_b;
        f_q   <= nx_f;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign out_valid = vld_q;
  assign acc_out   = acc_q;
  assign b_out     = b_q;
  assign cy_out    = f_q.cy;
  assign ac_out    = f_q.ac;
  assign ov_out    = f_q.ov;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic [7:0]   opcode,
  input logic [W-1:0] acc_in,
  input logic [W-1:0] b_in,
  input logic         cy_in,
  input logic         ac_in,
  input logic         ov_in,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] acc_out,
  input logic [W-1:0] b_out,
  input logic         cy_out,
  input logic         ac_out,
  input logic         ov_out
);
  logic take;
  assign take = in_valid & in_ready;

  // R11
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  // R12
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R12
  stall_holds_data_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(acc_out) && $stable(b_out)
                                   && $stable(cy_out) && $stable(ov_out)));

  // R9
  div_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (take && opcode == 8'h84 && b_in == '0) |=>
      (ov_out && !cy_out && acc_out == $past(acc_in) && b_out == $past(b_in)));

  // R8
  div_rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (take && opcode == 8'h84 && b_in != '0) |=>
      (!ov_out && !cy_out && b_out < $past(b_in)));

  // R6
  incdec_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (take && (opcode == 8'h04 || opcode == 8'h14)) |=>
      (cy_out == $past(cy_in) && ac_out == $past(ac_in) && ov_out == $past(ov_in)));

  // R4
  clear_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (take && opcode == 8'hE4) |=> (acc_out == '0));
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .opcode(opcode), .acc_in(acc_in), .b_in(b_in), .cy_in(cy_in),
  .ac_in(ac_in), .ov_in(ov_in), .out_valid(out_valid), .out_ready(out_ready),
  .acc_out(acc_out), .b_out(b_out), .cy_out(cy_out), .ac_out(ac_out),
  .ov_out(ov_out)
);

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, out_ready = 1'b1;
  logic [7:0] opcode = 8'h00, acc_in = 8'h00, opnd_in = 8'h00, b_in = 8'h00;
  logic       cy_in = 1'b0, ac_in = 1'b0, ov_in = 1'b0;
  logic       in_ready, out_valid, cy_out, ac_out, ov_out;
  logic [7:0] acc_out, b_out;
  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  acc_alu u_acc_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .opcode(opcode), .acc_in(acc_in), .opnd_in(opnd_in), .b_in(b_in),
    .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in), .out_valid(out_valid),
    .out_ready(out_ready), .acc_out(acc_out), .b_out(b_out),
    .cy_out(cy_out), .ac_out(ac_out), .ov_out(ov_out)
  );

  // expected {acc, b, cy, ac, ov}
  function automatic logic [18:0] model(input logic [7:0] op, a, o, b,
                                        input logic cy, ac, ov);
    int s, t;
    logic c1, cin;
    logic [7:0] na = a, nb = b;
    logic ncy = cy, nac = ac, nov = ov;
    casez (op)
      8'b0010_1???, 8'b0010_011?, 8'b0011_1???, 8'b0011_011?: begin
        cin = (op[4] == 1'b1) ? cy : 1'b0;
        s   = int'(a) + int'(o) + int'(cin);
        na  = 8'(s);
        ncy = s > 255;
        nac = (int'(a % 16) + int'(o % 16) + int'(cin)) > 15;
        nov = (a[7] == o[7]) && (na[7] != a[7]);
      end
      8'b0101_1???, 8'b0101_011?: na = a & o;
      8'hE4: na = 8'h00;
      8'hF4: na = ~a;
      8'hC3: ncy = 1'b0;
      8'hB3: ncy = ~cy;
      8'h04: na = a + 8'd1;
      8'h14: na = a - 8'd1;
      8'hD4: begin
        t = int'(a);
        if ((a % 16) > 9 || ac) t = t + 6;
        c1 = t > 255;
        t = t % 256;
        if ((t / 16) > 9 || cy || c1) t = t + 96;
        ncy = cy | c1 | (t > 255);
        na  = 8'(t);
      end
      8'h84: begin
        ncy = 1'b0;
        if (b == 8'h00) nov = 1'b1;
        else begin
          na = a / b; nb = a % b; nov = 1'b0;
        end
      end
      default: ;
    endcase
    return {na, nb, ncy, nac, nov};
  endfunction

  task automatic check(input string tag, input logic [18:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [7:0] op, a, o, b,
                        input logic cy, ac, ov);
    logic [18:0] exp;
    exp = model(op, a, o, b, cy, ac, ov);
    @(negedge clk);
    opcode = op; acc_in = a; opnd_in = o; b_in = b;
    cy_in = cy; ac_in = ac; ov_in = ov; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {18'd0, out_valid}, 19'd1);
    check(tag, {acc_out, b_out, cy_out, ac_out, ov_out}, exp);
  endtask

  task automatic t_reset;
    check("R13 reset", {acc_out, b_out, cy_out, ac_out, ov_out, out_valid}, 20'd0);
  endtask

  task automatic t_add;
    run_op("R1 add plain",    8'h2A, 8'h12, 8'h34, 8'h00, 1'b0, 1'b0, 1'b0);
    run_op("R1 add carry+ac", 8'h28, 8'hF8, 8'h0F, 8'h00, 1'b0, 1'b1, 1'b1);
    run_op("R1 add overflow", 8'h26, 8'h70, 8'h10, 8'h00, 1'b1, 1'b1, 1'b0);
    run_op("R1 add neg ovf",  8'h2F, 8'h80, 8'h80, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_addc;
    run_op("R2 addc cin ac",  8'h3B, 8'h0F, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
    run_op("R2 addc wrap",    8'h37, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1);
    run_op("R2 addc no cin",  8'h36, 8'h41, 8'h3F, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_logic;
    run_op("R3 and reg",  8'h5D, 8'hF0, 8'h3C, 8'h11, 1'b1, 1'b0, 1'b1);
    run_op("R3 and ind",  8'h57, 8'hAA, 8'h0F, 8'h22, 1'b0, 1'b1, 1'b0);
    run_op("R4 clear a",  8'hE4, 8'h5A, 8'h00, 8'h33, 1'b1, 1'b1, 1'b1);
    run_op("R4 cpl a",    8'hF4, 8'h5A, 8'h00, 8'h33, 1'b0, 1'b1, 1'b0);
    run_op("R5 clear cy", 8'hC3, 8'h77, 8'h00, 8'h44, 1'b1, 1'b1, 1'b1);
    run_op("R5 cpl cy 0", 8'hB3, 8'h77, 8'h00, 8'h44, 1'b0, 1'b0, 1'b1);
    run_op("R5 cpl cy 1", 8'hB3, 8'h77, 8'h00, 8'h44, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_incdec;
    run_op("R6 inc wrap", 8'h04, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
    run_op("R6 dec wrap", 8'h14, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1);
    run_op("R6 inc mid",  8'h04, 8'h3F, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_da;
    run_op("R7 da both",   8'hD4, 8'h9A, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    run_op("R7 da ac",     8'hD4, 8'h15, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
    run_op("R7 da cy",     8'hD4, 8'h23, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1);
    run_op("R7 da step1c", 8'hD4, 8'hFB, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    run_op("R7 da none",   8'hD4, 8'h45, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_div;
    run_op("R8 div",       8'h84, 8'd200, 8'h00, 8'd7,  1'b1, 1'b1, 1'b1);
    run_op("R8 div small", 8'h84, 8'd5,   8'h00, 8'd9,  1'b1, 1'b0, 1'b0);
    run_op("R8 div one",   8'h84, 8'hFF,  8'h00, 8'd1,  1'b0, 1'b0, 1'b1);
    run_op("R9 div zero",  8'h84, 8'h63,  8'h00, 8'h00, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_other;
    run_op("R10 pass 00", 8'h00, 8'h9C, 8'h11, 8'h5E, 1'b1, 1'b0, 1'b1);
    run_op("R10 pass A5", 8'hA5, 8'h21, 8'hFF, 8'h07, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_handshake;
    @(negedge clk);
    check("R11 idle", {18'd0, out_valid}, 19'd0);
    out_ready = 1'b0;
    opcode = 8'h04; acc_in = 8'h10; opnd_in = 8'h00; b_in = 8'h00;
    cy_in = 1'b0; ac_in = 1'b0; ov_in = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check("R12 ready low", {18'd0, in_ready}, 19'd0);
    opcode = 8'hE4; acc_in = 8'h55;
    @(negedge clk);
    check("R12 held", {acc_out, b_out, cy_out, ac_out, ov_out, out_valid},
          {8'h11, 8'h00, 3'b000, 1'b1});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R12 next taken", {acc_out, b_out, cy_out, ac_out, ov_out, out_valid},
          {8'h00, 8'h00, 3'b000, 1'b1});
    @(negedge clk);
    check("R11 drains", {18'd0, out_valid}, 19'd0);
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_add();
    t_addc();
    t_logic();
    t_incdec();
    t_da();
    t_div();
    t_other();
    t_handshake();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule